// File: doc/BRIEF.md
# Flags Register and Branch Evaluator

This block holds the 16-bit processor status word of a small processor core and decides the sixteen short conditional branches. The execute stage drives flag changes into it as per-bit set and clear strobes from the ALU, as carry, interrupt and direction commands, as a full 16-bit write, or as a byte load that replaces the low half of the word. The low byte of the status word is always available on a separate output, so it can be copied into a general register.

For a short branch, the execute stage presents the 4-bit condition code, the 8-bit displacement and the address of the next instruction. The block reports combinationally whether the branch is taken, judged on the current flags. On the execute strobe it registers the next instruction pointer: the presented address plus the sign-extended displacement when taken, or the presented address unchanged when not taken.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset the status word reads 0x0002 and the registered instruction pointer reads 0.
- R2: A full write stores the input ANDed with 0xFFD7 and ORed with 0x0002. Bit 1 always reads one, and bits 3 and 5 always read zero.
- R3: A byte load replaces bits 7:0 with the byte input and keeps bits 15:8. The same reserved-bit rule as R2 then applies.
- R4: The byte output always equals bits 7:0 of the status word.
- R5: ALU strobes clear each bit flagged in the clear vector and then set each bit flagged in the set vector, so a set wins over a clear on the same bit. Bits without a strobe keep their value, and the reserved-bit rule of R2 still holds.
- R6: Command codes are 1 = clear carry (bit 0), 2 = set carry, 3 = clear interrupt (bit 9), 4 = set interrupt, 5 = clear direction (bit 10) and 6 = set direction. Codes 0 and 7 do nothing. A command merges with the ALU strobes of the same cycle.
- R7: Flag positions are carry bit 0, parity bit 2, zero bit 6, sign bit 7 and overflow bit 11. Condition codes 0 to 15 test, in this order: OF, !OF, CF, !CF, ZF, !ZF, CF|ZF, !(CF|ZF), SF, !SF, PF, !PF, SF^OF, !(SF^OF), ZF|(SF^OF), and !(ZF|(SF^OF)). The taken output reflects the current flags in the same cycle.
- R8: On the execute strobe the pointer register loads the presented address plus the sign-extended displacement, modulo 2^16, if the branch is taken. If it is not taken, the register loads the presented address unchanged.
- R9: Without the execute strobe the pointer register holds its value.
- R10: In one cycle a full write beats a byte load, and a byte load beats the strobes and commands.
- R11: With no write, load, strobe or command the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_wr_i | input | 1 | Full status word write |
| full_data_i | input | 16 | Full write data |
| byte_ld_i | input | 1 | Low byte load |
| byte_data_i | input | 8 | Low byte load data |
| alu_set_i | input | 16 | Per-bit set strobes |
| alu_clr_i | input | 16 | Per-bit clear strobes |
| cmd_i | input | 3 | Flag command code (R6) |
| br_exec_i | input | 1 | Branch execute strobe |
| br_cond_i | input | 4 | Condition code (R7) |
| br_disp_i | input | 8 | Signed displacement |
| ip_i | input | 16 | Address of the next instruction |
| flags_o | output | 16 | Status word |
| byte_o | output | 8 | Low byte of the status word |
| taken_o | output | 1 | Branch condition is true |
| ip_o | output | 16 | Registered next instruction pointer |

## Verification
The bench builds the block with its default widths: a 16-bit pointer and an 8-bit displacement. At these widths all sixteen condition codes can be swept against all 32 combinations of the five tested flags, and all 256 displacements can be applied near both ends of the address space, so wraparound is covered. Every single-bit strobe position, every command code and every reserved-bit corner are also applied exhaustively.

// File: rtl/flag_branch_pkg.sv
package flag_branch_pkg;
  localparam int PSW_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [PSW_W-1:0] RSV_KEEP = 16'hFFD7;
  localparam logic [PSW_W-1:0] RSV_ONE  = 16'h0002;
  localparam logic [PSW_W-1:0] PSW_RST  = RSV_ONE;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int IF_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_CLR_CF = 3'd1,
    CMD_SET_CF = 3'd2,
    CMD_CLR_IF = 3'd3,
    CMD_SET_IF = 3'd4,
    CMD_CLR_DF = 3'd5,
    CMD_SET_DF = 3'd6,
    CMD_RSVD   = 3'd7
  } flag_cmd_e;

  typedef struct packed {
    logic [PSW_W-1:0] set;
    logic [PSW_W-1:0] clr;
  } flag_mask_t;
endpackage

// File: rtl/fb_status_word.sv
module fb_status_word import flag_branch_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_wr_i,
  input  logic [PSW_W-1:0]  full_data_i,
  input  logic              byte_ld_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic [PSW_W-1:0]  set_i,
  input  logic [PSW_W-1:0]  clr_i,
  output logic [PSW_W-1:0]  flags_o
);
  logic [PSW_W-1:0] flags_q, raw, flags_d;

  always_comb begin
    raw = (flags_q & ~clr_i) | set_i;
    if (byte_ld_i) raw = {flags_q[PSW_W-1:BYTE_W], byte_data_i};
    if (full_wr_i) raw = full_data_i;
    flags_d = (raw & RSV_KEEP) | RSV_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= PSW_RST;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fb_cond_eval.sv
module fb_cond_eval import flag_branch_pkg::*; (
  input  logic [PSW_W-1:0] flags_i,
  input  logic [3:0]       cond_i,
  output logic             taken_o
);
  logic cf, pf, zf, sf, of_f, lt, base;

  assign cf   = flags_i[CF_BIT];
  assign pf   = flags_i[PF_BIT];
  assign zf   = flags_i[ZF_BIT];
  assign sf   = flags_i[SF_BIT];
  assign of_f = flags_i[OF_BIT];
  assign lt   = sf ^ of_f;

  // even code tests the condition, odd code its negation
  always_comb begin
    unique case (cond_i[3:1])
      3'd0: base = of_f;
      3'd1: base = cf;
      3'd2: base = zf;
      3'd3: base = cf | zf;
      3'd4: base = sf;
      3'd5: base = pf;
      3'd6: base = lt;
      default: base = zf | lt;
    endcase
  end

  assign taken_o = base ^ cond_i[0];
endmodule

// File: rtl/fb_ip_step.sv
module fb_ip_step #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic              taken_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [IP_W-1:0]   ip_i,
  output logic [IP_W-1:0]   ip_o
);
  localparam int EXT_W = IP_W - DISP_W;

  logic [IP_W-1:0] disp_ext, ip_q;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[IP_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ip_q <= '0;
    else if (exec_i) ip_q <= taken_i ? ip_i + disp_ext : ip_i;
  end

  assign ip_o = ip_q;
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit import flag_branch_pkg::*; #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_wr_i,
  input  logic [PSW_W-1:0]  full_data_i,
  input  logic              byte_ld_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic [PSW_W-1:0]  alu_set_i,
  input  logic [PSW_W-1:0]  alu_clr_i,
  input  logic [2:0]        cmd_i,
  input  logic              br_exec_i,
  input  logic [3:0]        br_cond_i,
  input  logic [DISP_W-1:0] br_disp_i,
  input  logic [IP_W-1:0]   ip_i,
  output logic [PSW_W-1:0]  flags_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              taken_o,
  output logic [IP_W-1:0]   ip_o
);
  flag_mask_t cmd_m;

  always_comb begin
    cmd_m = '0;
    unique case (flag_cmd_e'(cmd_i))
      CMD_CLR_CF: cmd_m.clr[CF_BIT] = 1'b1;
      CMD_SET_CF: cmd_m.set[CF_BIT] = 1'b1;
      CMD_CLR_IF: cmd_m.clr[IF_BIT] = 1'b1;
      CMD_SET_IF: cmd_m.set[IF_BIT] = 1'b1;
      CMD_CLR_DF: cmd_m.clr[DF_BIT] = 1'b1;
      CMD_SET_DF: cmd_m.set[DF_BIT] = 1'b1;
      default: ;
    endcase
  end

  fb_status_word u_psw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .full_wr_i  (full_wr_i),
    .full_data_i(full_data_i),
    .byte_ld_i  (byte_ld_i),
    .byte_data_i(byte_data_i),
    .set_i      (alu_set_i | cmd_m.set),
    .clr_i      (alu_clr_i | cmd_m.clr),
    .flags_o    (flags_o)
  );

  fb_cond_eval u_cond (
    .flags_i(flags_o),
    .cond_i (br_cond_i),
    .taken_o(taken_o)
  );

  fb_ip_step #(.IP_W(IP_W), .DISP_W(DISP_W)) u_ip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exec_i (br_exec_i),
    .taken_i(taken_o),
    .disp_i (br_disp_i),
    .ip_i   (ip_i),
    .ip_o   (ip_o)
  );

  assign byte_o = flags_o[BYTE_W-1:0];
endmodule

// File: rtl/fb_checker.sv
module fb_checker import flag_branch_pkg::*; #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_wr_i,
  input logic [PSW_W-1:0]  full_data_i,
  input logic              byte_ld_i,
  input logic [BYTE_W-1:0] byte_data_i,
  input logic [PSW_W-1:0]  alu_set_i,
  input logic [PSW_W-1:0]  alu_clr_i,
  input logic [2:0]        cmd_i,
  input logic              br_exec_i,
  input logic              taken_o,
  input logic [IP_W-1:0]   ip_i,
  input logic [PSW_W-1:0]  flags_o,
  input logic [IP_W-1:0]   ip_o
);
  p_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] && !flags_o[3] && !flags_o[5]);

  p_full_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_wr_i |=> flags_o == (($past(full_data_i) & RSV_KEEP) | RSV_ONE));

  p_byte_high_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ld_i && !full_wr_i) |=> flags_o[PSW_W-1:BYTE_W] == $past(flags_o[PSW_W-1:BYTE_W]));

  p_not_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_exec_i && !taken_o) |=> ip_o == $past(ip_i));

  p_ip_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_exec_i |=> $stable(ip_o));

  p_full_beats_all_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wr_i && byte_ld_i) |=> flags_o[BYTE_W-1:0] == (($past(full_data_i[BYTE_W-1:0]) & 8'hD7) | 8'h02));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_wr_i && !byte_ld_i && alu_set_i == '0 && alu_clr_i == '0 &&
     (cmd_i == 3'd0 || cmd_i == 3'd7)) |=> $stable(flags_o));

  logic unused_ok;
  assign unused_ok = ^byte_data_i;
endmodule

bind flag_branch_unit fb_checker #(.IP_W(IP_W), .DISP_W(DISP_W)) u_fb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .full_wr_i  (full_wr_i),
  .full_data_i(full_data_i),
  .byte_ld_i  (byte_ld_i),
  .byte_data_i(byte_data_i),
  .alu_set_i  (alu_set_i),
  .alu_clr_i  (alu_clr_i),
  .cmd_i      (cmd_i),
  .br_exec_i  (br_exec_i),
  .taken_o    (taken_o),
  .ip_i       (ip_i),
  .flags_o    (flags_o),
  .ip_o       (ip_o)
);

// File: tb/flag_branch_unit_test.sv
module flag_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        full_wr = 1'b0;
  logic [15:0] full_data = '0;
  logic        byte_ld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [15:0] alu_set = '0;
  logic [15:0] alu_clr = '0;
  logic [2:0]  cmd = '0;
  logic        br_exec = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [7:0]  br_disp = '0;
  logic [15:0] ip_in = '0;
  logic [15:0] flags;
  logic [7:0]  byte_out;
  logic        taken;
  logic [15:0] ip_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model;

  always #2 clk = ~clk;

  flag_branch_unit uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .full_wr_i(full_wr), .full_data_i(full_data),
    .byte_ld_i(byte_ld), .byte_data_i(byte_data),
    .alu_set_i(alu_set), .alu_clr_i(alu_clr), .cmd_i(cmd),
    .br_exec_i(br_exec), .br_cond_i(br_cond), .br_disp_i(br_disp), .ip_i(ip_in),
    .flags_o(flags), .byte_o(byte_out), .taken_o(taken), .ip_o(ip_out)
  );

  function automatic logic [15:0] fix(input logic [15:0] v);
    return (v & 16'hFFD7) | 16'h0002;
  endfunction

  function automatic logic cond_ref(input logic [3:0] c, input logic [15:0] f);
    logic cf, pf, zf, sf, ov;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; ov = f[11];
    case (c)
      4'h0: return ov;
      4'h1: return !ov;
      4'h2: return cf;
      4'h3: return !cf;
      4'h4: return zf;
      4'h5: return !zf;
      4'h6: return cf || zf;
      4'h7: return !cf && !zf;
      4'h8: return sf;
      4'h9: return !sf;
      4'hA: return pf;
      4'hB: return !pf;
      4'hC: return sf != ov;
      4'hD: return sf == ov;
      4'hE: return zf || (sf != ov);
      default: return !zf && (sf == ov);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    full_wr = 0; byte_ld = 0; alu_set = '0; alu_clr = '0; cmd = '0; br_exec = 0;
  endtask

  task automatic write_full(input logic [15:0] v);
    full_wr = 1; full_data = v;
    step();
    idle();
    model = fix(v);
  endtask

  function automatic logic [15:0] cmd_apply(input logic [2:0] c, input logic [15:0] f);
    logic [15:0] r;
    r = f;
    case (c)
      3'd1: r[0] = 0;
      3'd2: r[0] = 1;
      3'd3: r[9] = 0;
      3'd4: r[9] = 1;
      3'd5: r[10] = 0;
      3'd6: r[10] = 1;
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 flags", {16'h0, flags}, 32'h0002);
    check("R1 ip", {16'h0, ip_out}, 32'h0);
    rst_ni = 1;
    @(negedge clk);
    model = 16'h0002;

    // R2 full write masking, R4 byte out
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'h1 << i;
      write_full(v);
      check("R2 single bit", {16'h0, flags}, {16'h0, fix(v)});
      check("R4 byte out", {24'h0, byte_out}, {24'h0, fix(v) & 16'h00FF});
      write_full(~v);
      check("R2 single zero", {16'h0, flags}, {16'h0, fix(~v)});
    end

    // R3 byte load keeps high byte
    write_full(16'hA5C3);
    for (int b = 0; b < 256; b += 17) begin
      byte_ld = 1; byte_data = b[7:0];
      step();
      idle();
      model = fix({model[15:8], b[7:0]});
      check("R3 byte load", {16'h0, flags}, {16'h0, model});
    end

    // R11 hold with no request
    repeat (3) step();
    check("R11 idle hold", {16'h0, flags}, {16'h0, model});
    cmd = 3'd7;
    step();
    idle();
    check("R11 code 7 no effect", {16'h0, flags}, {16'h0, model});

    // R5 strobes per bit
    write_full(16'h0000);
    for (int i = 0; i < 16; i++) begin
      alu_set = 16'h1 << i;
      step();
      idle();
      model = fix(model | (16'h1 << i));
      check("R5 set strobe", {16'h0, flags}, {16'h0, model});
    end
    for (int i = 0; i < 16; i++) begin
      alu_clr = 16'h1 << i;
      step();
      idle();
      model = fix(model & ~(16'h1 << i));
      check("R5 clear strobe", {16'h0, flags}, {16'h0, model});
    end
    alu_set = 16'h00F0; alu_clr = 16'h0FF0;
    step();
    idle();
    model = fix((model & ~16'h0FF0) | 16'h00F0);
    check("R5 set beats clear", {16'h0, flags}, {16'h0, model});

    // R6 commands from two starting points
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        write_full(s == 0 ? 16'h0000 : 16'hFFFF);
        cmd = c[2:0];
        step();
        idle();
        model = fix(cmd_apply(c[2:0], model));
        check("R6 command", {16'h0, flags}, {16'h0, model});
      end
    end
    write_full(16'h0000);
    cmd = 3'd2; alu_set = 16'h0800;
    step();
    idle();
    model = fix(16'h0801);
    check("R6 command merges with strobe", {16'h0, flags}, {16'h0, model});

    // R10 priorities
    write_full(16'h1200);
    full_wr = 1; full_data = 16'h00FF; byte_ld = 1; byte_data = 8'h00; alu_set = 16'hFF00;
    step();
    idle();
    model = fix(16'h00FF);
    check("R10 full wins", {16'h0, flags}, {16'h0, model});
    byte_ld = 1; byte_data = 8'hC1; alu_set = 16'hFFFF; cmd = 3'd4;
    step();
    idle();
    model = fix({model[15:8], 8'hC1});
    check("R10 byte load wins", {16'h0, flags}, {16'h0, model});

    // R7/R8 condition sweep over the five tested flags
    for (int m = 0; m < 32; m++) begin
      logic [15:0] f;
      f = '0;
      f[0] = m[0]; f[2] = m[1]; f[6] = m[2]; f[7] = m[3]; f[11] = m[4];
      write_full(f);
      for (int c = 0; c < 16; c++) begin
        logic exp_t;
        br_cond = c[3:0]; br_disp = 8'hF6; ip_in = 16'h1000 + 16'(c); br_exec = 1;
        #0.5;
        exp_t = cond_ref(c[3:0], fix(f));
        check("R7 condition", {31'h0, taken}, {31'h0, exp_t});
        step();
        idle();
        check("R8 ip update", {16'h0, ip_out},
              {16'h0, exp_t ? 16'h1000 + 16'(c) - 16'd10 : 16'h1000 + 16'(c)});
      end
    end

    // R8 displacement sweep incl. wraparound; R9 hold
    write_full(16'h0000);
    for (int d = 0; d < 256; d++) begin
      logic [15:0] base;
      base = d[0] ? 16'hFFF0 : 16'h0005;
      br_cond = 4'hB; br_disp = d[7:0]; ip_in = base; br_exec = 1;
      step();
      idle();
      check("R8 taken disp", {16'h0, ip_out}, {16'h0, base + {{8{d[7]}}, d[7:0]}});
    end
    br_cond = 4'hA; br_disp = 8'h7F; ip_in = 16'h4321; br_exec = 1;
    step();
    idle();
    check("R8 not taken", {16'h0, ip_out}, 32'h4321);
    ip_in = 16'h9999; br_cond = 4'hB;
    step();
    step();
    check("R9 ip hold", {16'h0, ip_out}, 32'h4321);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule